// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit forms the byte address that a load or store puts on the memory bus of a 32-bit processor. It also forms the updated base value for instructions that change their base register. The offset comes from one of two sources. The first is a 12-bit two's-complement immediate. The second is an index register value, which may be shifted logically left or right and is then added to or subtracted from the base.

Three addressing modes pick which value goes to memory and whether the base register is written back. Offset mode issues base plus offset and does not touch the base register. Pre-indexed mode issues base plus offset and writes that same value back. Post-indexed mode issues the unchanged base and writes base plus offset back. Because the program counter can be given as the base in offset mode, the unit also serves PC-relative accesses.

The unit is registered. Each cycle with `req_valid` high yields one result and a one-cycle `done` pulse on the next clock edge. Register-file access, the memory data path, alignment checks and instruction decode are all outside this block.

Top module: `agu_top`

## Requirements
- R1: A cycle with `req_valid` high produces `done` high in the following cycle only, and the outputs hold that request's results.
- R2: While `rst_n` is low, `done`, `wb_en`, `mem_addr` and `wb_val` are all zero.
- R3: With `use_index` = 0, the 12-bit immediate is sign-extended to 32 bits and added to the base. In this case `sub_off`, `shift_kind` and `shift_amt` have no effect.
- R4: With `use_index` = 1, the shifted index is added to the base when `sub_off` = 0 and subtracted from it when `sub_off` = 1.
- R5: A `shift_kind` of 0 shifts the index logically left and 1 shifts it logically right with zero fill. The shift distance is `shift_amt` (0 to 31), and 0 means no shift. Bits shifted past either end are lost.
- R6: Mode code 0 (offset) issues base plus offset on `mem_addr` with `wb_en` = 0. In every mode, `wb_val` carries base plus offset.
- R7: Mode code 1 (pre-indexed) issues base plus offset on `mem_addr` and sets `wb_en` = 1, so `wb_val` equals `mem_addr`.
- R8: Mode code 2 (post-indexed) issues the unmodified base on `mem_addr` and sets `wb_en` = 1, with `wb_val` = base plus offset.
- R9: All sums and differences wrap modulo 2^32. No overflow indication exists.
- R10: Mode code 3 behaves exactly as offset mode.
- R11: In a cycle without `req_valid`, the next cycle keeps `mem_addr`, `wb_en` and `wb_val` unchanged and `done` low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe; inputs are sampled in this cycle |
| base_val | input | 32 | Base register contents (may be the PC) |
| index_val | input | 32 | Index register magnitude |
| imm_off | input | 12 | Signed immediate offset |
| use_index | input | 1 | 1 = index register offset, 0 = immediate |
| sub_off | input | 1 | 1 = subtract index offset, 0 = add |
| shift_kind | input | 1 | 0 = logical left, 1 = logical right |
| shift_amt | input | 5 | Index shift distance, 0 = none |
| mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 as offset |
| done | output | 1 | One-cycle result strobe |
| mem_addr | output | 32 | Address issued to memory |
| wb_en | output | 1 | Base register writeback enable |
| wb_val | output | 32 | New base value |

## Verification
On every cycle, the bound checker checks the timing of `done` against the request strobe and checks that the outputs are held when no request arrives. It also checks the relationships each mode imposes: the post-indexed address equals the sampled base, pre-indexed writeback equals the address, and `wb_en` follows the mode. In addition, it checks that the immediate path never selects subtraction. The offset arithmetic itself can only be shown by the bench's directed scenarios: the sign extension of the immediate, left and right shifts at distances 0, 1 and 31, subtraction of the index, and wraparound past 2^32. The bench compares these against values it computes independently.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_OFFSET = 2'd0,
    AM_PRE    = 2'd1,
    AM_POST   = 2'd2,
    AM_ALT    = 2'd3
  } agu_mode_e;

  typedef enum logic {
    SK_LEFT  = 1'b0,
    SK_RIGHT = 1'b1
  } agu_shift_e;

  function automatic logic mode_writes_back(input logic [1:0] m);
    return (m == AM_PRE) || (m == AM_POST);
  endfunction

  function automatic logic mode_issues_base(input logic [1:0] m);
    return m == AM_POST;
  endfunction
endpackage

// File: rtl/agu_shifter.sv
module agu_shifter #(
  parameter int W    = 32,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    din,
  input  logic            go_right,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout
);
  localparam int STAGES = SH_W;

  logic [W-1:0] stage [0:STAGES];

  assign stage[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    localparam int DIST = 2 ** g;
    logic [W-1:0] moved;
    assign moved        = go_right ? (stage[g] >> DIST) : (stage[g] << DIST);
    assign stage[g + 1] = amt[g] ? moved : stage[g];
  end

  assign dout = stage[STAGES];
endmodule

// File: rtl/agu_offset_gen.sv
module agu_offset_gen #(
  parameter int W     = 32,
  parameter int IMM_W = 12,
  parameter int SH_W  = 5
) (
  input  logic [W-1:0]     index_val,
  input  logic [IMM_W-1:0] imm_off,
  input  logic             use_index,
  input  logic             sub_off,
  input  logic             shift_kind,
  input  logic [SH_W-1:0]  shift_amt,
  output logic [W-1:0]     off_term,
  output logic             off_negate
);
  localparam int EXT_W = W - IMM_W;

  function automatic logic [W-1:0] widen_imm(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  logic [W-1:0] shifted_index;

  agu_shifter #(.W(W), .SH_W(SH_W)) u_shift (
    .din      (index_val),
    .go_right (shift_kind),
    .amt      (shift_amt),
    .dout     (shifted_index)
  );

  always_comb begin
    if (use_index) begin
      off_term   = shifted_index;
      off_negate = sub_off;
    end else begin
      off_term   = widen_imm(imm_off);
      off_negate = 1'b0;
    end
  end
endmodule

// File: rtl/agu_combine.sv
module agu_combine #(
  parameter int W = 32
) (
  input  logic [W-1:0] base_val,
  input  logic [W-1:0] off_term,
  input  logic         off_negate,
  output logic [W-1:0] target
);
  function automatic logic [W-1:0] wrap_sum(input logic [W-1:0] a,
                                            input logic [W-1:0] b,
                                            input logic         neg);
    logic [W-1:0] bx;
    bx = neg ? ~b : b;
    return a + bx + {{(W-1){1'b0}}, neg};
  endfunction

  assign target = wrap_sum(base_val, off_term, off_negate);
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic              use_index,
  input  logic              sub_off,
  input  logic              shift_kind,
  input  logic [SH_W-1:0]   shift_amt,
  input  logic [1:0]        mode,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_val
);
  logic [ADDR_W-1:0] off_term;
  logic              off_negate;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] issue_addr;
  logic              issue_wb;
  logic              capture;

  agu_offset_gen #(.W(ADDR_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
    .index_val  (index_val),
    .imm_off    (imm_off),
    .use_index  (use_index),
    .sub_off    (sub_off),
    .shift_kind (shift_kind),
    .shift_amt  (shift_amt),
    .off_term   (off_term),
    .off_negate (off_negate)
  );

  agu_combine #(.W(ADDR_W)) u_sum (
    .base_val   (base_val),
    .off_term   (off_term),
    .off_negate (off_negate),
    .target     (target)
  );

  assign issue_addr = mode_issues_base(mode) ? base_val : target;
  assign issue_wb   = mode_writes_back(mode);
  assign capture    = req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      mem_addr <= '0;
      wb_en    <= 1'b0;
      wb_val   <= '0;
    end else begin
      done <= capture;
      if (capture) begin
        mem_addr <= issue_addr;
        wb_en    <= issue_wb;
        wb_val   <= target;
      end
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              use_index,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] base_val,
  input logic              off_negate,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wb_en,
  input logic [ADDR_W-1:0] wb_val
);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);

  p_no_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done);

  p_hold_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(mem_addr) && $stable(wb_val) && $stable(wb_en)));

  p_imm_adds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !use_index |-> !off_negate);

  p_wb_follows_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (wb_en == ($past(mode) == 2'd1 || $past(mode) == 2'd2)));

  p_pre_same_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'd1) |=> (mem_addr == wb_val));

  p_post_issues_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'd2) |=> (mem_addr == $past(base_val)));
endmodule

bind agu_top agu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .use_index  (use_index),
  .mode       (mode),
  .base_val   (base_val),
  .off_negate (off_negate),
  .done       (done),
  .mem_addr   (mem_addr),
  .wb_en      (wb_en),
  .wb_val     (wb_val)
);

// File: tb/sim_agu_top.sv
module sim_agu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] base_val = '0;
  logic [31:0] index_val = '0;
  logic [11:0] imm_off = '0;
  logic        use_index = 1'b0;
  logic        sub_off = 1'b0;
  logic        shift_kind = 1'b0;
  logic [4:0]  shift_amt = '0;
  logic [1:0]  mode = '0;
  logic        done;
  logic [31:0] mem_addr;
  logic        wb_en;
  logic [31:0] wb_val;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  agu_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
    .index_val(index_val), .imm_off(imm_off), .use_index(use_index),
    .sub_off(sub_off), .shift_kind(shift_kind), .shift_amt(shift_amt),
    .mode(mode), .done(done), .mem_addr(mem_addr), .wb_en(wb_en), .wb_val(wb_val)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference offset: computed with wide arithmetic, not a barrel shifter.
  function automatic logic [31:0] ref_target(input logic [31:0] b, input logic [31:0] ix,
      input logic [11:0] im, input logic ui, input logic sb, input logic sk,
      input logic [4:0] sa);
    longint unsigned v;
    longint signed   s;
    if (!ui) begin
      s = longint'($signed(im));
      return b + 32'(s);
    end
    v = longint'(ix);
    if (sk) v = v / (64'd1 << sa);
    else    v = (v * (64'd1 << sa)) & 64'hFFFF_FFFF;
    if (sb) return b - 32'(v);
    return b + 32'(v);
  endfunction

  task automatic run_req(input string tag, input logic [31:0] b, input logic [31:0] ix,
      input logic [11:0] im, input logic ui, input logic sb, input logic sk,
      input logic [4:0] sa, input logic [1:0] md);
    logic [31:0] tgt;
    logic [31:0] ea;
    tgt = ref_target(b, ix, im, ui, sb, sk, sa);
    ea  = (md == 2'd2) ? b : tgt;
    @(negedge clk);
    base_val = b; index_val = ix; imm_off = im; use_index = ui;
    sub_off = sb; shift_kind = sk; shift_amt = sa; mode = md; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R1 done"}, {31'd0, done}, 32'd1);
    chk({tag, " addr"}, mem_addr, ea);
    chk({tag, " wb_val"}, wb_val, tgt);
    chk({tag, " wb_en"}, {31'd0, wb_en}, {31'd0, (md == 2'd1 || md == 2'd2)});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R2 done", {31'd0, done}, 32'd0);
    chk("R2 addr", mem_addr, 32'd0);
    chk("R2 wb_en", {31'd0, wb_en}, 32'd0);
    chk("R2 wb_val", wb_val, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_immediate();
    run_req("R3 imm pos", 32'h0000_1000, 32'h0, 12'h07F, 1'b0, 1'b0, 1'b0, 5'd0, 2'd0);
    run_req("R3 imm neg", 32'h0000_1000, 32'h0, 12'hFFC, 1'b0, 1'b0, 1'b0, 5'd0, 2'd0);
    run_req("R3 imm min sub ignored", 32'h0000_2000, 32'hFFFF, 12'h800, 1'b0, 1'b1, 1'b1, 5'd7, 2'd0);
  endtask

  task automatic t_index();
    run_req("R4 add", 32'h0001_0000, 32'h0000_0123, 12'h0, 1'b1, 1'b0, 1'b0, 5'd0, 2'd0);
    run_req("R4 sub", 32'h0001_0000, 32'h0000_0123, 12'h0, 1'b1, 1'b1, 1'b0, 5'd0, 2'd0);
  endtask

  task automatic t_shift();
    run_req("R5 lsl2", 32'h0000_0100, 32'h0000_0011, 12'h0, 1'b1, 1'b0, 1'b0, 5'd2, 2'd0);
    run_req("R5 lsr4", 32'h0000_0100, 32'hF000_00F0, 12'h0, 1'b1, 1'b0, 1'b1, 5'd4, 2'd0);
    run_req("R5 lsl31", 32'h0, 32'h0000_0003, 12'h0, 1'b1, 1'b0, 1'b0, 5'd31, 2'd0);
    run_req("R5 lsr31", 32'h0, 32'h8000_0000, 12'h0, 1'b1, 1'b0, 1'b1, 5'd31, 2'd0);
    run_req("R5 lsr1 sub", 32'h0000_0040, 32'h0000_0081, 12'h0, 1'b1, 1'b1, 1'b1, 5'd1, 2'd0);
  endtask

  task automatic t_modes();
    run_req("R6 offset pc", 32'h0000_8008, 32'h0, 12'hFF0, 1'b0, 1'b0, 1'b0, 5'd0, 2'd0);
    run_req("R7 pre", 32'h2000_0000, 32'h10, 12'h0, 1'b1, 1'b0, 1'b0, 5'd2, 2'd1);
    run_req("R8 post", 32'h2000_0000, 32'h10, 12'h0, 1'b1, 1'b1, 1'b0, 5'd1, 2'd2);
    run_req("R8 post imm", 32'h3000_0004, 32'h0, 12'h004, 1'b0, 1'b0, 1'b0, 5'd0, 2'd2);
    run_req("R10 mode3", 32'h4000_0000, 32'h8, 12'h0, 1'b1, 1'b0, 1'b0, 5'd3, 2'd3);
  endtask

  task automatic t_wrap();
    run_req("R9 add wrap", 32'hFFFF_FFF0, 32'h0000_0020, 12'h0, 1'b1, 1'b0, 1'b0, 5'd0, 2'd1);
    run_req("R9 sub wrap", 32'h0000_0004, 32'h0000_0001, 12'h0, 1'b1, 1'b1, 1'b0, 5'd4, 2'd1);
    run_req("R9 imm wrap", 32'h0000_0002, 32'h0, 12'hFFD, 1'b0, 1'b0, 1'b0, 5'd0, 2'd2);
  endtask

  task automatic t_hold();
    logic [31:0] a0;
    logic [31:0] w0;
    logic        e0;
    run_req("R11 setup", 32'h5555_0000, 32'h4, 12'h0, 1'b1, 1'b0, 1'b0, 5'd1, 2'd1);
    a0 = mem_addr; w0 = wb_val; e0 = wb_en;
    base_val = 32'hDEAD_BEEF; index_val = 32'h1234; mode = 2'd0; use_index = 1'b0;
    @(negedge clk);
    chk("R1 single pulse", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R11 done low", {31'd0, done}, 32'd0);
    chk("R11 addr held", mem_addr, a0);
    chk("R11 wb_val held", wb_val, w0);
    chk("R11 wb_en held", {31'd0, wb_en}, {31'd0, e0});
  endtask

  initial begin
    t_reset();
    t_immediate();
    t_index();
    t_shift();
    t_modes();
    t_wrap();
    t_hold();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule